// File: doc/BRIEF.md
# 8-bit Arithmetic and Logic Unit with Registered Flags

This block is the arithmetic and logic unit of a small 8-bit processor that has no decimal mode. Each transfer carries two operands, a carry input and a 4-bit operation code. The block covers logical, binary add and subtract, compare, shift, rotate, increment, decrement and bit-test operations. One clock after a transfer is accepted, it registers the result byte together with the negative, zero, carry and overflow flags. Each operation updates only the flags it owns. All other flags, and for compare and bit test the result byte as well, keep their previous values. This lets the surrounding core feed the registered flags straight into its status register.

Operands enter on a valid/ready stream. A transfer is taken on a clock edge where `in_valid` and `in_ready` are both high. The registered result is offered on `out_valid` and consumed on a clock edge where `out_ready` is also high. The block is one stage deep. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While the consumer holds `out_ready` low with a result pending, `in_ready` stays low and result and flags hold. A source must keep its operands stable while `in_valid` is high and `in_ready` is low.

Top module: `alu8_core`

## Requirements
- R1: A transfer is accepted on a clock edge with `in_valid` and `in_ready` both high. `out_valid` is high after that edge. `in_ready` equals `!out_valid || out_ready`. `out_valid` falls after an edge with `out_ready` high and no new transfer.
- R2: While `out_valid` is high and `out_ready` is low, `result`, all flags and `out_valid` hold their values and no transfer is accepted.
- R3: Codes 0 (OR), 1 (AND) and 2 (XOR) write A|B, A&B and A^B to `result`. They set N from bit 7 and Z when the value is zero. C and V are unchanged.
- R4: Code 3 (add with carry) writes A+B+carry_in mod 256. It sets C to the carry out of bit 7, and V when A and B share a sign that differs from the sign of the sum. N and Z are set as in R3.
- R5: Code 4 (subtract with borrow) writes A+~B+carry_in, where a carry of 1 means no borrow. C, V, N and Z are formed as in R4 with ~B as the second operand.
- R6: Code 5 (compare) forms A+~B+1 and ignores `carry_in`. It sets C when A>=B unsigned, Z when A==B, and N from bit 7 of the difference. `result` and V are unchanged.
- R7: Code 6 shifts A left and code 7 shifts A right, filling the vacated bit with 0. C receives the bit shifted out. N and Z follow the new value and V is unchanged.
- R8: Code 8 rotates A left and code 9 rotates A right through carry. `carry_in` fills the vacated bit and C receives the bit shifted out. N and Z follow the new value and V is unchanged.
- R9: Code 10 writes A+1 and code 11 writes A-1, both mod 256. Only N and Z change.
- R10: Code 12 (bit test) sets Z when A&B is zero, N to B bit 7 and V to B bit 6. C and `result` are unchanged.
- R11: Codes 13 to 15 are accepted and raise `out_valid`, but leave `result` and all flags unchanged.
- R12: After reset `result` is 0, all flags are 0, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and code are offered |
| in_ready | output | 1 | Block can take a transfer this cycle |
| op | input | 4 | Operation code (see requirements) |
| opnd_a | input | 8 | Operand A |
| opnd_b | input | 8 | Operand B |
| carry_in | input | 1 | Carry input for add, subtract and rotates |
| out_valid | output | 1 | Registered result and flags are pending |
| out_ready | input | 1 | Consumer takes the pending result |
| result | output | 8 | Registered result byte |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The bench targets signed overflow at both ends of the range: 0x50+0x50 and 0x80-0x01. A design that derived V from the raw B operand instead of the inverted one would misreport the subtract case. It checks that compare with equal operands yields Z and C set while the result byte is left alone; a compare that honoured `carry_in` or wrote its difference would show a changed result or a cleared C. It drives rotates with both carry polarities and checks that increment, decrement, compare and bit test keep the flags they do not own, where a unit that cleared unowned flags would lose a previously set V or C. A held `out_ready` then tests that a second transfer is refused and that the pending result survives.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_OR   = 4'd0,
    OP_AND  = 4'd1,
    OP_XOR  = 4'd2,
    OP_ADD  = 4'd3,
    OP_SUB  = 4'd4,
    OP_CMP  = 4'd5,
    OP_SHL  = 4'd6,
    OP_SHR  = 4'd7,
    OP_ROTL = 4'd8,
    OP_ROTR = 4'd9,
    OP_INC  = 4'd10,
    OP_DEC  = 4'd11,
    OP_TEST = 4'd12
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] cy;
  assign cy[0] = cin;

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
    assign sum[gi]  = x[gi] ^ y[gi] ^ cy[gi];
    assign cy[gi+1] = (x[gi] & y[gi]) | (cy[gi] & (x[gi] ^ y[gi]));
  end

  assign cout = cy[WIDTH];
  assign ovf  = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] val,
  input  logic             go_right,
  input  logic             fill,
  output logic [WIDTH-1:0] shifted,
  output logic             out_bit
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    if (go_right) begin
      shifted = {fill, val[MSB:1]};
      out_bit = val[0];
    end else begin
      shifted = {val[MSB-1:0], fill};
      out_bit = val[MSB];
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             carry_in,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] result,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v
);
  import alu8_pkg::*;

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] res_q;
  alu_flags_t       flg_q;
  logic             vld_q;
  logic             accept;

  assign in_ready = !vld_q || out_ready;
  assign accept   = in_valid && in_ready;

  // main adder: add, subtract, compare
  logic             is_add, is_cmp;
  logic [WIDTH-1:0] add_y, add_sum;
  logic             add_cin, add_cout, add_ovf;

  assign is_add  = (op == OP_ADD);
  assign is_cmp  = (op == OP_CMP);
  assign add_y   = is_add ? opnd_b : ~opnd_b;
  assign add_cin = is_cmp ? 1'b1 : carry_in;

  alu8_adder #(.WIDTH(WIDTH)) u_main_add (
    .x(opnd_a), .y(add_y), .cin(add_cin),
    .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
  );

  // step adder: increment and decrement
  logic             is_dec;
  logic [WIDTH-1:0] step_y, step_sum;
  logic             step_cout, step_ovf;

  assign is_dec = (op == OP_DEC);
  assign step_y = is_dec ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

  alu8_adder #(.WIDTH(WIDTH)) u_step_add (
    .x(opnd_a), .y(step_y), .cin(!is_dec),
    .sum(step_sum), .cout(step_cout), .ovf(step_ovf)
  );

  // shifter: shifts and rotates
  logic             sh_right, sh_rot, sh_fill, sh_out;
  logic [WIDTH-1:0] sh_val;

  assign sh_right = (op == OP_SHR) || (op == OP_ROTR);
  assign sh_rot   = (op == OP_ROTL) || (op == OP_ROTR);
  assign sh_fill  = sh_rot ? carry_in : 1'b0;

  alu8_shifter #(.WIDTH(WIDTH)) u_shift (
    .val(opnd_a), .go_right(sh_right), .fill(sh_fill),
    .shifted(sh_val), .out_bit(sh_out)
  );

  // selection of next result and flags
  logic [WIDTH-1:0] nxt_res;
  alu_flags_t       nxt_flg;
  logic [WIDTH-1:0] test_and;

  assign test_and = opnd_a & opnd_b;

  always_comb begin
    nxt_res = res_q;
    nxt_flg = flg_q;
    unique case (op)
      OP_OR:   nxt_res = opnd_a | opnd_b;
      OP_AND:  nxt_res = opnd_a & opnd_b;
      OP_XOR:  nxt_res = opnd_a ^ opnd_b;
      OP_ADD, OP_SUB: begin
        nxt_res   = add_sum;
        nxt_flg.c = add_cout;
        nxt_flg.v = add_ovf;
      end
      OP_SHL, OP_SHR, OP_ROTL, OP_ROTR: begin
        nxt_res   = sh_val;
        nxt_flg.c = sh_out;
      end
      OP_INC, OP_DEC: nxt_res = step_sum;
      OP_CMP: begin
        nxt_flg.n = add_sum[MSB];
        nxt_flg.z = (add_sum == '0);
        nxt_flg.c = add_cout;
      end
      OP_TEST: begin
        nxt_flg.n = opnd_b[MSB];
        nxt_flg.v = opnd_b[MSB-1];
        nxt_flg.z = (test_and == '0);
      end
      default: ;
    endcase
    if (op <= OP_ROTR && op != OP_CMP || op == OP_INC || op == OP_DEC) begin
      nxt_flg.n = nxt_res[MSB];
      nxt_flg.z = (nxt_res == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      flg_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (accept) begin
        res_q <= nxt_res;
        flg_q <= nxt_flg;
        vld_q <= 1'b1;
      end else if (out_ready) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
  assign flag_n    = flg_q.n;
  assign flag_z    = flg_q.z;
  assign flag_c    = flg_q.c;
  assign flag_v    = flg_q.v;

endmodule

// File: rtl/alu8_checker.sv
module alu8_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [3:0]       op,
  input logic [WIDTH-1:0] opnd_b,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] result,
  input logic             flag_n,
  input logic             flag_z,
  input logic             flag_c,
  input logic             flag_v
);
  logic acc;
  logic writes;
  assign acc    = in_valid && in_ready;
  assign writes = (op <= 4'd4) || (op >= 4'd6 && op <= 4'd11);

  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid); // R1

  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(result)
      && $stable({flag_n, flag_z, flag_c, flag_v})); // R2

  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && writes |=> flag_z == (result == '0)); // R3

  AST_CMP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op == 4'd5 |=> $stable(result) && $stable(flag_v)); // R6

  AST_STEP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (op == 4'd10 || op == 4'd11) |=> $stable(flag_c) && $stable(flag_v)); // R9

  AST_TEST_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op == 4'd12 |=> flag_n == $past(opnd_b[WIDTH-1])
      && flag_v == $past(opnd_b[WIDTH-2]) && $stable(result) && $stable(flag_c)); // R10

  AST_RESERVED_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op >= 4'd13 |=> $stable(result)
      && $stable({flag_n, flag_z, flag_c, flag_v})); // R11

endmodule

bind alu8_core alu8_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .op(op), .opnd_b(opnd_b), .out_valid(out_valid), .out_ready(out_ready),
  .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
  .flag_v(flag_v)
);

// File: tb/tb_alu8_core.sv
`timescale 1ns/1ps
module tb_alu8_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] op = '0;
  logic [7:0] opnd_a = '0, opnd_b = '0;
  logic       carry_in = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] result;
  logic       flag_n, flag_z, flag_c, flag_v;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  alu8_core dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
    .out_valid(out_valid), .out_ready(out_ready), .result(result),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  // {op, a, b, cin, expected result, expected NZCV}, applied in order
  localparam int NV = 22;
  localparam logic [32:0] VEC [NV] = '{
    {4'd3,  8'h50, 8'h50, 1'b0, 8'hA0, 4'b1001}, // R4 positive overflow
    {4'd3,  8'hFF, 8'h01, 1'b0, 8'h00, 4'b0110}, // R4 carry, zero
    {4'd3,  8'h80, 8'hFF, 1'b1, 8'h80, 4'b1010}, // R4 carry-in used
    {4'd4,  8'h50, 8'hF0, 1'b1, 8'h60, 4'b0000}, // R5 borrow
    {4'd4,  8'h80, 8'h01, 1'b1, 8'h7F, 4'b0011}, // R5 negative overflow
    {4'd5,  8'h10, 8'h10, 1'b0, 8'h7F, 4'b0111}, // R6 equal, cin ignored
    {4'd5,  8'h05, 8'h06, 1'b1, 8'h7F, 4'b1001}, // R6 less than
    {4'd0,  8'h0F, 8'hF0, 1'b0, 8'hFF, 4'b1001}, // R3 or
    {4'd1,  8'h0F, 8'hF0, 1'b0, 8'h00, 4'b0101}, // R3 and
    {4'd2,  8'hAA, 8'hFF, 1'b0, 8'h55, 4'b0001}, // R3 xor
    {4'd6,  8'h81, 8'h00, 1'b1, 8'h02, 4'b0011}, // R7 shift left zero-fill
    {4'd7,  8'h01, 8'h00, 1'b1, 8'h00, 4'b0111}, // R7 shift right
    {4'd8,  8'h80, 8'h00, 1'b1, 8'h01, 4'b0011}, // R8 rotate left cin=1
    {4'd9,  8'h01, 8'h00, 1'b0, 8'h00, 4'b0111}, // R8 rotate right cin=0
    {4'd9,  8'h02, 8'h00, 1'b1, 8'h81, 4'b1001}, // R8 rotate right cin=1
    {4'd10, 8'hFF, 8'h00, 1'b0, 8'h00, 4'b0101}, // R9 increment wrap
    {4'd11, 8'h00, 8'h00, 1'b0, 8'hFF, 4'b1001}, // R9 decrement wrap
    {4'd14, 8'h12, 8'h34, 1'b1, 8'hFF, 4'b1001}, // R11 reserved code
    {4'd12, 8'h0F, 8'hC0, 1'b0, 8'hFF, 4'b1101}, // R10 test zero
    {4'd12, 8'hFF, 8'h01, 1'b0, 8'hFF, 4'b0000}, // R10 test nonzero
    {4'd4,  8'h00, 8'h00, 1'b0, 8'hFF, 4'b1000}, // R5 with borrow in
    {4'd3,  8'h7F, 8'h00, 1'b1, 8'h80, 4'b1001}  // R4 carry-in overflow
  };

  task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic send(input logic [3:0] c, input logic [7:0] a, input logic [7:0] b,
                      input logic ci);
    op = c; opnd_a = a; opnd_b = b; carry_in = ci; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", {result, flag_n, flag_z, flag_c, flag_v},
          {8'h00, 4'b0000});
    check("R12", {10'd0, out_valid, in_ready}, {10'd0, 1'b0, 1'b1});
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][32:29], VEC[i][28:21], VEC[i][20:13], VEC[i][12]);
      check("R1", {11'd0, out_valid}, 12'd1);
      check("R3-R11 vector", {result, flag_n, flag_z, flag_c, flag_v}, VEC[i][11:0]);
    end

    // R1 out_valid drops after an idle drained cycle
    @(negedge clk);
    check("R1", {11'd0, out_valid}, 12'd0);

    // R2 back-pressure: pending result holds, second transfer refused
    out_ready = 1'b0;
    send(4'd3, 8'h01, 8'h01, 1'b0);
    check("R2", {result, flag_n, flag_z, flag_c, flag_v}, {8'h02, 4'b0000});
    check("R2", {10'd0, out_valid, in_ready}, {10'd0, 1'b1, 1'b0});
    op = 4'd0; opnd_a = 8'hFF; opnd_b = 8'h00; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R2", {result, flag_n, flag_z, flag_c, flag_v}, {8'h02, 4'b0000});
    check("R2", {10'd0, out_valid, in_ready}, {10'd0, 1'b1, 1'b0});
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1", {result, flag_n, flag_z, flag_c, flag_v}, {8'hFF, 4'b1000});
    check("R1", {10'd0, out_valid, in_ready}, {10'd0, 1'b1, 1'b1});
    @(negedge clk);
    check("R1", {11'd0, out_valid}, 12'd0);

    // R12 reset mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    check("R12", {result, flag_n, flag_z, flag_c, flag_v}, 12'h000);
    rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule